// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight interrupt request lines, resolves them by fixed priority and signals the processor with a single interrupt output. When the processor acknowledges, the block returns an 8-bit vector formed from a programmable base and the number of the winning input. Software reaches it through an 8-bit register port with one address bit. A write with the address bit low and data bit 4 set begins a short configuration sequence. Once that sequence is complete, further writes either set the mask or issue commands: end-of-interrupt and read-select.

Two instances can be chained. The leading controller owns the interrupt output. Some of its inputs are marked as carrying a follower. When such an input wins an acknowledge, the leader does not drive a vector. It presents the input number on its cascade outputs instead, and the follower whose programmed identity matches supplies the vector on the same acknowledge. An end-of-interrupt can be specific or can target the highest-priority in-service level. Automatic end-of-interrupt is also available. An acknowledge that finds no eligible request produces the level-7 vector and leaves the in-service state unchanged.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the mask reads 0xFF at address 1, and a read at address 0 returns the request register, which is 0x00.
- R2: A write at address 0 with data bit 4 set clears the mask, the request register and the in-service register, and selects the request register for reads. The next address-1 writes then load, in order, the vector base, then the cascade byte (skipped when bit 1 of the first word is 1), then the mode byte (skipped when bit 0 of the first word is 0, in which case automatic end-of-interrupt is off).
- R3: An acknowledge pulse in which an input wins gives, one cycle later, a one-cycle vector-valid pulse. The vector is the base (bits 7:3 of the base word) plus the input number.
- R4: Outside the configuration sequence, an address-1 write loads the mask. A 1 bit stops that input from raising the interrupt output, and an address-1 read returns the mask.
- R5: Writing 0x0B at address 0 makes address-0 reads return the in-service register. Writing 0x0A makes them return the request register.
- R6: Input 0 has the highest priority. A pending unmasked request raises the interrupt output only when its priority is strictly above every set in-service bit.
- R7: A request bit is set by a rising edge on its input. It is cleared when the input goes low, and it is cleared when that input wins an acknowledge.
- R8: Writing 0x60+L at address 0 clears in-service bit L only. Writing 0x20 clears the highest-priority set in-service bit.
- R9: With bit 1 of the mode byte set (automatic end-of-interrupt), an acknowledge delivers the vector but leaves no in-service bit set.
- R10: An acknowledge when no unmasked request is eligible returns base+7 and changes no in-service bit, whatever the mask holds.
- R11: In cascade, the leader (cascade byte bit N set for input N) delivers no vector for a winning input N. It drives cas_hit_o with the input number on cas_id_o and sets its own in-service bit N. A follower (cascade byte bits 2:0 give its identity) answers an acknowledge only when cas_id_i equals its identity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_a0_i | input | 1 | Register address bit |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| req_i | input | 8 | Interrupt request lines, input 0 highest |
| int_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | One-cycle acknowledge pulse |
| cas_lead_i | input | 1 | 1: leader or standalone, 0: follower |
| cas_id_i | input | 3 | Cascade identity presented by the leader |
| cas_id_o | output | 3 | Number of the current winning input |
| cas_hit_o | output | 1 | Current winner has a follower behind it |
| vec_o | output | 8 | Acknowledged vector |
| vec_vld_o | output | 1 | Vector valid pulse |

## Verification
The assertions assume that an acknowledge is a single-cycle pulse followed by at least one idle cycle. They also assume that no register write lands in the same cycle as an acknowledge, and that a follower's acknowledge is gated by the leader's cas_hit_o with cas_id_o fed to its cas_id_i. The stimulus follows these rules: every acknowledge and every write is issued through tasks that raise the strobe for one cycle and drop it before the next operation. In the cascade test, the follower's acknowledge wire is built from the leader's outputs exactly as that wiring rule describes.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      CFG_RUN  = 2'd0,
      CFG_BASE = 2'd1,
      CFG_LINK = 2'd2,
      CFG_MODE = 2'd3
   } cfg_st_e;

   localparam logic [2:0] EOI_ONE = 3'b011;
   localparam logic [2:0] EOI_TOP = 3'b001;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
   import pic_pkg::*;
#(
   parameter int N_IN = 8,
   parameter int DW   = 8,
   localparam int LW  = $clog2(N_IN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic            a0_i,
   input  logic [DW-1:0]   wdata_i,
   output logic            init_o,
   output logic [DW-1:0]   base_o,
   output logic [N_IN-1:0] link_o,
   output logic            single_o,
   output logic            aeoi_o,
   output logic [N_IN-1:0] mask_o,
   output logic            rsel_isr_o,
   output logic            eoi_one_o,
   output logic            eoi_top_o,
   output logic [LW-1:0]   eoi_lvl_o
);
   cfg_st_e st_q;
   logic    ic4_q;
   logic    cmd_wr, data_wr, ocw2_wr, ocw3_wr;

   assign init_o  = wr_i && !a0_i && wdata_i[4];
   assign cmd_wr  = wr_i && !a0_i && !wdata_i[4];
   assign ocw2_wr = cmd_wr && !wdata_i[3];
   assign ocw3_wr = cmd_wr && wdata_i[3];
   assign data_wr = wr_i && a0_i;

   assign eoi_one_o = ocw2_wr && (wdata_i[7:5] == EOI_ONE);
   assign eoi_top_o = ocw2_wr && (wdata_i[7:5] == EOI_TOP);
   assign eoi_lvl_o = wdata_i[LW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= CFG_RUN;
         base_o     <= '0;
         link_o     <= '0;
         single_o   <= 1'b1;
         ic4_q      <= 1'b0;
         aeoi_o     <= 1'b0;
         mask_o     <= '1;
         rsel_isr_o <= 1'b0;
      end else if (init_o) begin
         st_q       <= CFG_BASE;
         single_o   <= wdata_i[1];
         ic4_q      <= wdata_i[0];
         aeoi_o     <= 1'b0;
         mask_o     <= '0;
         rsel_isr_o <= 1'b0;
      end else if (data_wr) begin
         unique case (st_q)
            CFG_BASE: begin
               base_o <= {wdata_i[DW-1:LW], {LW{1'b0}}};
               if (!single_o)  st_q <= CFG_LINK;
               else if (ic4_q) st_q <= CFG_MODE;
               else            st_q <= CFG_RUN;
            end
            CFG_LINK: begin
               link_o <= wdata_i[N_IN-1:0];
               st_q   <= ic4_q ? CFG_MODE : CFG_RUN;
            end
            CFG_MODE: begin
               aeoi_o <= wdata_i[1];
               st_q   <= CFG_RUN;
            end
            default: mask_o <= wdata_i[N_IN-1:0];
         endcase
      end else if (ocw3_wr && wdata_i[1]) begin
         rsel_isr_o <= wdata_i[0];
      end
   end

   AST_MASK_HELD_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !init_o && st_q != CFG_RUN) |=> $stable(mask_o)); // R2
   AST_INIT_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      init_o |=> (mask_o == '0 && !rsel_isr_o)); // R2
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
   parameter int N_IN = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_all_i,
   input  logic [N_IN-1:0] req_i,
   input  logic [N_IN-1:0] take_i,
   output logic [N_IN-1:0] irr_o
);
   for (genvar g = 0; g < N_IN; g++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q   <= 1'b0;
            irr_o[g] <= 1'b0;
         end else begin
            prev_q <= req_i[g];
            if (clr_all_i) irr_o[g] <= 1'b0;
            else irr_o[g] <= (irr_o[g] | (req_i[g] & ~prev_q)) & req_i[g] & ~take_i[g];
         end
      end

      AST_IRR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         !req_i[g] |=> !irr_o[g]); // R7
      AST_IRR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irr_o[g]) |-> $past(req_i[g])); // R7
   end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
   parameter int N_IN = 8,
   localparam int LW  = $clog2(N_IN)
) (
   input  logic [N_IN-1:0] req_i,
   input  logic [N_IN-1:0] isr_i,
   output logic [N_IN-1:0] win_oh_o,
   output logic            hit_o,
   output logic [LW-1:0]   lvl_o
);
   logic [N_IN:0] req_seen;
   logic [N_IN:0] isr_seen;

   assign req_seen[0] = 1'b0;
   assign isr_seen[0] = 1'b0;

   for (genvar g = 0; g < N_IN; g++) begin : g_lvl
      assign req_seen[g+1] = req_seen[g] | req_i[g];
      assign isr_seen[g+1] = isr_seen[g] | isr_i[g];
      assign win_oh_o[g]   = req_i[g] & ~req_seen[g] & ~isr_seen[g+1];
   end

   assign hit_o = |win_oh_o;

   always_comb begin
      lvl_o = '0;
      for (int i = 0; i < N_IN; i++)
         if (win_oh_o[i]) lvl_o = LW'(i);
   end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
   parameter int N_IN = 8,
   parameter int DW   = 8,
   localparam int LW  = $clog2(N_IN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr_i,
   input  logic            reg_a0_i,
   input  logic [DW-1:0]   reg_wdata_i,
   output logic [DW-1:0]   reg_rdata_o,
   input  logic [N_IN-1:0] req_i,
   output logic            int_o,
   input  logic            ack_i,
   input  logic            cas_lead_i,
   input  logic [LW-1:0]   cas_id_i,
   output logic [LW-1:0]   cas_id_o,
   output logic            cas_hit_o,
   output logic [DW-1:0]   vec_o,
   output logic            vec_vld_o
);
   if (N_IN != 8 || DW != 8) begin : g_bad_cfg
      $error("pic_ctrl: command encoding needs N_IN == 8 and DW == 8");
   end

   logic            init_w, single_w, aeoi_w, rsel_w, eoi_one_w, eoi_top_w, hit_w, to_slave_w, accept_w;
   logic [DW-1:0]   base_w;
   logic [N_IN-1:0] link_w, mask_w, irr_w, isr_q, win_oh_w, take_w, set_w, clr_w;
   logic [LW-1:0]   eoi_lvl_w, win_lvl_w;

   pic_cfg_regs #(.N_IN(N_IN), .DW(DW)) cfg_i (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .a0_i(reg_a0_i), .wdata_i(reg_wdata_i),
      .init_o(init_w), .base_o(base_w), .link_o(link_w), .single_o(single_w),
      .aeoi_o(aeoi_w), .mask_o(mask_w), .rsel_isr_o(rsel_w),
      .eoi_one_o(eoi_one_w), .eoi_top_o(eoi_top_w), .eoi_lvl_o(eoi_lvl_w)
   );

   pic_req_latch #(.N_IN(N_IN)) req_i_latch (
      .clk(clk), .rst_n(rst_n), .clr_all_i(init_w), .req_i(req_i),
      .take_i(take_w), .irr_o(irr_w)
   );

   pic_prio_pick #(.N_IN(N_IN)) pick_i (
      .req_i(irr_w & ~mask_w), .isr_i(isr_q),
      .win_oh_o(win_oh_w), .hit_o(hit_w), .lvl_o(win_lvl_w)
   );

   assign accept_w   = ack_i && (cas_lead_i || (cas_id_i == link_w[LW-1:0]));
   assign to_slave_w = cas_lead_i && !single_w && link_w[win_lvl_w];
   assign take_w     = (accept_w && hit_w) ? win_oh_w : '0;
   assign set_w      = aeoi_w ? '0 : take_w;

   always_comb begin
      clr_w = '0;
      if (eoi_one_w)      clr_w = N_IN'(1) << eoi_lvl_w;
      else if (eoi_top_w) clr_w = isr_q & (~isr_q + N_IN'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q     <= '0;
         vec_o     <= '0;
         vec_vld_o <= 1'b0;
      end else begin
         if (init_w) isr_q <= '0;
         else        isr_q <= (isr_q & ~clr_w) | set_w;
         vec_vld_o <= accept_w && !(hit_w && to_slave_w);
         if (accept_w)
            vec_o <= hit_w ? (base_w | DW'(win_lvl_w)) : (base_w | DW'({LW{1'b1}}));
      end
   end

   assign int_o       = hit_w;
   assign cas_id_o    = win_lvl_w;
   assign cas_hit_o   = hit_w && to_slave_w;
   assign reg_rdata_o = reg_a0_i ? DW'(mask_w) : (rsel_w ? DW'(isr_q) : DW'(irr_w));

   logic [N_IN-1:0] upto_w;
   assign upto_w = (N_IN'(2) << cas_id_o) - N_IN'(1);

   AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_vld_o |=> !vec_vld_o); // R3
   AST_VEC_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_vld_o) |-> $past(ack_i)); // R3
   AST_INT_ABOVE_ISR: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> ((isr_q & upto_w) == '0)); // R6
   AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_w)); // R7
   AST_AEOI_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (aeoi_w && !init_w) |=> ((isr_q & ~$past(isr_q)) == '0)); // R9
   AST_SPURIOUS_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_w && !int_o) |=> (vec_vld_o && vec_o[LW-1:0] == '1 && (isr_q & ~$past(isr_q)) == '0)); // R10
   AST_LEAD_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_w && cas_hit_o) |=> !vec_vld_o); // R11
   AST_FOLLOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_lead_i && ack_i && cas_id_i != link_w[LW-1:0]) |=> !vec_vld_o); // R11
endmodule

// File: tb/pic_ctrl_tb_top.sv
`timescale 1ns/100ps
module pic_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       m_wr = 0, m_a0 = 0, s_wr = 0, s_a0 = 0, ack = 0;
   logic [7:0] m_wd = 0, s_wd = 0, m_req = 0, s_req = 0;
   logic [7:0] m_rd, s_rd, m_vec, s_vec;
   logic       m_int, s_int, m_vld, s_vld, m_chit, s_chit;
   logic [2:0] m_cid, s_cid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   pic_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(m_wr), .reg_a0_i(m_a0), .reg_wdata_i(m_wd),
      .reg_rdata_o(m_rd), .req_i(m_req), .int_o(m_int), .ack_i(ack),
      .cas_lead_i(1'b1), .cas_id_i(3'd0), .cas_id_o(m_cid), .cas_hit_o(m_chit),
      .vec_o(m_vec), .vec_vld_o(m_vld)
   );

   pic_ctrl slv_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(s_wr), .reg_a0_i(s_a0), .reg_wdata_i(s_wd),
      .reg_rdata_o(s_rd), .req_i(s_req), .int_o(s_int), .ack_i(ack & m_chit),
      .cas_lead_i(1'b0), .cas_id_i(m_cid), .cas_id_o(s_cid), .cas_hit_o(s_chit),
      .vec_o(s_vec), .vec_vld_o(s_vld)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference of the leading instance
   bit [7:0] e_irr, e_isr, e_mask, e_prev, e_base, e_link, e_vec;
   bit       e_rsel, e_single, e_ic4, e_aeoi, e_vld;
   int       e_st;

   function automatic int pick();
      for (int i = 0; i < 8; i++) begin
         if (e_isr[i]) return -1;
         if (e_irr[i] && !e_mask[i]) return i;
      end
      return -1;
   endfunction

   function automatic bit [7:0] rd_exp(bit a0);
      return a0 ? e_mask : (e_rsel ? e_isr : e_irr);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         e_irr = 0; e_isr = 0; e_mask = 8'hFF; e_prev = 0; e_base = 0; e_link = 0;
         e_rsel = 0; e_single = 1; e_ic4 = 0; e_aeoi = 0; e_vld = 0; e_vec = 0; e_st = 0;
      end else begin
         automatic int w = pick();
         automatic bit [7:0] nirr = (e_irr | (m_req & ~e_prev)) & m_req;
         automatic bit [7:0] nisr = e_isr;
         e_prev = m_req;
         e_vld = 0;
         if (ack) begin
            if (w >= 0) begin
               nirr[w] = 0;
               if (!e_aeoi) nisr[w] = 1;
               if (e_single || !e_link[w]) begin e_vld = 1; e_vec = e_base + 8'(w); end
            end else begin
               e_vld = 1; e_vec = e_base + 8'd7;
            end
         end
         if (m_wr && !m_a0 && m_wd[4]) begin
            nirr = 0; nisr = 0; e_mask = 0; e_rsel = 0; e_aeoi = 0;
            e_single = m_wd[1]; e_ic4 = m_wd[0]; e_st = 1;
         end else if (m_wr && !m_a0) begin
            if (m_wd[3]) begin
               if (m_wd[1]) e_rsel = m_wd[0];
            end else if (m_wd[7:5] == 3'd3) begin
               nisr[m_wd[2:0]] = 0;
            end else if (m_wd[7:5] == 3'd1) begin
               for (int i = 7; i >= 0; i--) if (e_isr[i]) w = i;
               if (e_isr != 0) nisr[w] = 0;
            end
         end else if (m_wr && m_a0) begin
            case (e_st)
               1: begin e_base = m_wd & 8'hF8; e_st = !e_single ? 2 : (e_ic4 ? 3 : 0); end
               2: begin e_link = m_wd; e_st = e_ic4 ? 3 : 0; end
               3: begin e_aeoi = m_wd[1]; e_st = 0; end
               default: e_mask = m_wd;
            endcase
         end
         e_irr = nirr;
         e_isr = nisr;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         automatic int w = pick();
         chk("R6 int_o", m_int, w >= 0);
         chk("R3 vec_vld_o", m_vld, e_vld);
         if (e_vld) chk("R3 vec_o", m_vec, e_vec);
         chk("R11 cas_hit_o", m_chit, (w >= 0) && !e_single && e_link[w]);
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic mw(bit a0, bit [7:0] d);
      @(negedge clk); m_wr = 1; m_a0 = a0; m_wd = d;
      @(negedge clk); m_wr = 0;
   endtask
   task automatic sw(bit a0, bit [7:0] d);
      @(negedge clk); s_wr = 1; s_a0 = a0; s_wd = d;
      @(negedge clk); s_wr = 0;
   endtask
   task automatic mrd(bit a0, string tag);
      @(negedge clk); m_a0 = a0; #1;
      chk(tag, m_rd, rd_exp(a0));
   endtask
   task automatic mrd_lit(bit a0, bit [7:0] exp, string tag);
      @(negedge clk); m_a0 = a0; #1;
      chk(tag, m_rd, exp);
   endtask
   task automatic ack_pulse();
      @(negedge clk); ack = 1;
      @(negedge clk); ack = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1;
      // R1 reset state
      mrd_lit(1, 8'hFF, "R1 mask after reset");
      mrd_lit(0, 8'h00, "R1 request view after reset");
      chk("R1 int_o after reset", m_int, 0);

      // R2 full sequence, leader with follower on input 2
      mw(0, 8'h11); mw(1, 8'h20); mw(1, 8'h04); mw(1, 8'h01);
      mrd_lit(1, 8'h00, "R2 mask cleared by init");
      mw(1, 8'h02);
      mrd_lit(1, 8'h02, "R4 mask readback");
      @(negedge clk); m_req[1] = 1;
      idle(2);
      chk("R4 masked input raises nothing", m_int, 0);
      mrd_lit(0, 8'h02, "R7 edge latched while masked");
      mw(1, 8'h00);
      @(negedge clk); m_req[5] = 1;
      idle(1);
      chk("R4 unmasked raises int", m_int, 1);
      ack_pulse();
      chk("R3 vector for input 1", m_vec, 8'h21);
      chk("R6 lower level blocked by in-service", m_int, 0);
      mw(0, 8'h0B);
      mrd_lit(0, 8'h02, "R5 in-service view");
      @(negedge clk); m_req[0] = 1;
      idle(1);
      chk("R6 higher level preempts", m_int, 1);
      ack_pulse();
      chk("R3 vector for input 0", m_vec, 8'h20);
      mrd_lit(0, 8'h03, "R6 nested in-service");
      mw(0, 8'h61);
      mrd_lit(0, 8'h01, "R8 specific clears only level 1");
      mw(0, 8'h20);
      mrd_lit(0, 8'h00, "R8 nonspecific clears top level");
      idle(1);
      chk("R6 pending level 5 now forwarded", m_int, 1);
      ack_pulse();
      chk("R3 vector for input 5", m_vec, 8'h25);
      mw(0, 8'h65);
      mw(0, 8'h0A);
      mrd(0, "R5 request view restored");
      @(negedge clk); m_req = 0;
      idle(1);

      // R7 drop before acknowledge
      @(negedge clk); m_req[4] = 1;
      idle(1);
      @(negedge clk); m_req[4] = 0;
      idle(1);
      mrd_lit(0, 8'h00, "R7 dropped request cleared");

      // R10 spurious
      @(negedge clk); m_req[3] = 1;
      idle(1);
      @(negedge clk); m_req[3] = 0;
      ack_pulse();
      chk("R10 spurious vector", m_vec, 8'h27);
      chk("R10 spurious valid", m_vld, 1);
      mw(0, 8'h0B);
      mrd_lit(0, 8'h00, "R10 no in-service bit");
      mw(1, 8'hFF);
      ack_pulse();
      chk("R10 spurious with full mask", m_vec, 8'h27);

      // R2 single mode skips cascade byte, R9 automatic EOI
      mw(0, 8'h13); mw(1, 8'h40); mw(1, 8'h03); mw(1, 8'h00);
      mrd_lit(1, 8'h00, "R2 cascade byte skipped");
      mw(0, 8'h0B);
      @(negedge clk); m_req[2] = 1;
      idle(1);
      ack_pulse();
      chk("R9 vector in auto mode", m_vec, 8'h42);
      mrd_lit(0, 8'h00, "R9 nothing held in service");
      @(negedge clk); m_req = 0;

      // R2 no mode byte: normal EOI
      mw(0, 8'h12); mw(1, 8'h60); mw(1, 8'h00);
      mw(0, 8'h0B);
      @(negedge clk); m_req[6] = 1;
      idle(1);
      ack_pulse();
      chk("R2 vector without mode byte", m_vec, 8'h66);
      mrd_lit(0, 8'h40, "R2 normal EOI holds in-service");
      @(negedge clk); m_req = 0;

      // R11 cascade
      mw(0, 8'h11); mw(1, 8'h20); mw(1, 8'h04); mw(1, 8'h01); mw(1, 8'h00);
      sw(0, 8'h11); sw(1, 8'h28); sw(1, 8'h02); sw(1, 8'h01); sw(1, 8'h00);
      @(negedge clk); s_req[3] = 1;
      idle(1);
      chk("R11 follower raises int", s_int, 1);
      @(negedge clk); m_req[2] = 1;
      idle(1);
      chk("R11 leader names input 2", m_cid, 2);
      ack_pulse();
      chk("R11 follower valid", s_vld, 1);
      chk("R11 follower vector", s_vec, 8'h2B);
      chk("R11 leader silent", m_vld, 0);
      mw(0, 8'h0B);
      mrd_lit(0, 8'h04, "R11 leader in-service on input 2");
      sw(0, 8'h63); mw(0, 8'h62);
      mrd_lit(0, 8'h00, "R11 leader cleared");
      // identity mismatch
      @(negedge clk); s_req = 0; m_req = 0;
      sw(0, 8'h11); sw(1, 8'h28); sw(1, 8'h03); sw(1, 8'h01); sw(1, 8'h00);
      @(negedge clk); s_req[3] = 1;
      idle(1);
      @(negedge clk); m_req[2] = 1;
      idle(1);
      ack_pulse();
      chk("R11 mismatched follower silent", s_vld, 0);
      @(negedge clk); s_a0 = 0; #1;
      chk("R11 mismatched follower keeps request", s_rd, 8'h08);
      idle(2);

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule